// File: doc/BRIEF.md
# Serial Trigger Command Receiver

This block sits on a readout board and listens to a single serial line driven by the trigger board. The line rests low. A frame opens with one high start bit. After it come a fixed-length payload and an 8-bit check value. The line is sampled once per local clock, so each clock carries one frame bit. The receiver shifts in the payload and runs a bit-serial CRC over it. It then compares the result with the check value that arrives last.

A frame whose check value matches is delivered as a one-cycle `frame_valid` pulse. With that pulse come the decoded trigger kind (full trigger or event fragment only), the channel enable mask, the 32-bit event number and the 2-bit command. A command code of 3 asks the readout board to resynchronise its timestamp counters. For that code a `resync` pulse is raised together with `frame_valid`. A frame whose check value does not match raises a one-cycle `crc_err` pulse and is not delivered.

The controller has three states. `ST_IDLE` waits for the start bit. `ST_PAYLOAD` takes the 43 payload bits. `ST_CRC` takes the 8 check bits. Its transitions are:
- `ST_IDLE` goes to `ST_PAYLOAD` when it samples a high bit.
- `ST_PAYLOAD` goes to `ST_CRC` after its 43rd bit.
- `ST_CRC` goes back to `ST_IDLE` after its 8th bit, which is also when the verdict is registered.
- Every state holds otherwise.

Top module: `trig_cmd_rx`

## Requirements
- R1: After reset, `frame_valid`, `resync` and `crc_err` are 0, and `trig_full`, `ch_mask`, `event_id` and `cmd` are all zero.
- R2: While no frame is in progress, a low line level has no effect. No pulse appears and the data outputs keep their values.
- R3: After the start bit, the line carries the following, one bit per clock, each field MSB first: the trigger flag (1 bit), the channel mask (8 bits), the event ID (32 bits), the command (2 bits) and the CRC (8 bits). The result pulse is visible in the clock cycle right after the edge that samples the last CRC bit.
- R4: `trig_full` equals the received trigger flag. 1 means a full trigger and 0 means an event fragment only.
- R5: The CRC uses polynomial x^8+x^7+x^6+x^4+x^2+1 (0xD5) and starts from 0x00. It is computed bit-serially, MSB first, over the 43 bits from the trigger flag through the command. On a match, `frame_valid` is high for exactly one cycle and the decoded fields appear on the outputs.
- R6: On a mismatch, `crc_err` is high for exactly one cycle and `frame_valid` stays low. The data outputs keep the values of the last good frame.
- R7: `resync` pulses together with `frame_valid` only when the delivered command equals 3. It does not pulse for other commands or for a frame with a bad CRC.
- R8: A start bit sampled on the clock right after the last CRC bit begins a new frame, so frames can follow back to back.
- R9: `frame_valid` and `crc_err` are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial frame line, idle low |
| frame_valid | output | 1 | One-cycle pulse: a frame with a good CRC was received |
| trig_full | output | 1 | 1 = full trigger, 0 = event fragment only |
| ch_mask | output | 8 | Channel enable mask of the last good frame |
| event_id | output | 32 | Event number of the last good frame |
| cmd | output | 2 | Command code of the last good frame |
| resync | output | 1 | One-cycle pulse with `frame_valid` when the command is 3 |
| crc_err | output | 1 | One-cycle pulse: a frame with a bad CRC was dropped |

## Verification
The embedded assertions check several properties on every clock cycle:
- The valid and error pulses exclude each other and last only one cycle.
- A resync pulse only comes with a delivered resync command.
- The data outputs stay frozen across an error pulse.
- The controller leaves idle exactly on a high sample, and its bit counter stays in range.

Other behaviours depend on whole frames, so only the bench scenarios can show them. These are the field order and bit order, the CRC value for a given payload, the exact latency from the last CRC bit, and back-to-back frames. The bench sends frames with both trigger kinds, every command code, extreme masks and event numbers, corrupted check values and a long quiet stretch.

// File: rtl/trig_rx_pkg.sv
package trig_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_CRC     = 2'd2
    } rx_state_e;

    localparam int unsigned FLAG_W = 1;

endpackage

// File: rtl/trig_rx_crc8.sv
module trig_rx_crc8 #(
    parameter int unsigned CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'hD5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    logic             fb;
    logic [CRC_W-1:0] nxt;

    assign fb = crc[CRC_W-1] ^ din;

    // Serial LFSR step, one XOR level per register bit.
    assign nxt[0] = fb & POLY[0];
    for (genvar i = 1; i < CRC_W; i++) begin : g_step
        assign nxt[i] = crc[i-1] ^ (fb & POLY[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= nxt;
        end
    end

endmodule

// File: rtl/trig_rx_shreg.sv
module trig_rx_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (en) q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (en) q <= {q[W-2:0], din};
            end
        end
    endgenerate

endmodule

// File: rtl/trig_rx_ctrl.sv
module trig_rx_ctrl
    import trig_rx_pkg::*;
#(
    parameter int unsigned PAY_W = 43,
    parameter int unsigned CRC_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic start,
    output logic cap_pay,
    output logic cap_crc,
    output logic last_crc
);

    localparam int unsigned CNT_W = $clog2(PAY_W > CRC_W ? PAY_W : CRC_W);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAY_W - 1);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

    rx_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State and counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (line) state_nxt = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (cnt == PAY_LAST) begin
                    state_nxt = ST_CRC;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_CRC: begin
                if (cnt == CRC_LAST) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        start    = 1'b0;
        cap_pay  = 1'b0;
        cap_crc  = 1'b0;
        last_crc = 1'b0;
        unique case (state)
            ST_IDLE:    start   = line;
            ST_PAYLOAD: cap_pay = 1'b1;
            ST_CRC: begin
                cap_crc  = 1'b1;
                last_crc = (cnt == CRC_LAST);
            end
            default: ;
        endcase
    end

    // R8: a high sample in idle always opens a frame.
    a_r8_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && line) |=> (state == ST_PAYLOAD));

    // R2: a low sample in idle keeps the receiver idle.
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !line) |=> (state == ST_IDLE));

    // R3: the counter never passes the check field length in ST_CRC.
    a_r3_crc_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRC) |-> (cnt <= CRC_LAST));

    // R3: a payload is always followed by the check field.
    a_r3_pay_to_crc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD && cnt == PAY_LAST) |=> (state == ST_CRC && cnt == '0));

endmodule

// File: rtl/trig_cmd_rx.sv
module trig_cmd_rx
    import trig_rx_pkg::*;
#(
    parameter int unsigned       MASK_W      = 8,
    parameter int unsigned       EID_W       = 32,
    parameter int unsigned       CMD_W       = 2,
    parameter int unsigned       CRC_W       = 8,
    parameter logic [CRC_W-1:0]  CRC_POLY    = 8'hD5,
    parameter logic [CMD_W-1:0]  RESYNC_CODE = 2'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              frame_valid,
    output logic              trig_full,
    output logic [MASK_W-1:0] ch_mask,
    output logic [EID_W-1:0]  event_id,
    output logic [CMD_W-1:0]  cmd,
    output logic              resync,
    output logic              crc_err
);

    localparam int unsigned PAY_W   = FLAG_W + MASK_W + EID_W + CMD_W;
    localparam int unsigned CMD_LO  = 0;
    localparam int unsigned EID_LO  = CMD_LO + CMD_W;
    localparam int unsigned MASK_LO = EID_LO + EID_W;
    localparam int unsigned FLAG_LO = MASK_LO + MASK_W;

    logic             start, cap_pay, cap_crc, last_crc;
    logic [PAY_W-1:0] pay_q;
    logic [CRC_W-2:0] chk_q;
    logic [CRC_W-1:0] crc_calc;
    logic [CRC_W-1:0] crc_rx;
    logic             crc_ok;

    trig_rx_ctrl #(.PAY_W(PAY_W), .CRC_W(CRC_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (ser_in),
        .start    (start),
        .cap_pay  (cap_pay),
        .cap_crc  (cap_crc),
        .last_crc (last_crc)
    );

    trig_rx_shreg #(.W(PAY_W)) u_pay (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_pay),
        .din   (ser_in),
        .q     (pay_q)
    );

    trig_rx_shreg #(.W(CRC_W-1)) u_chk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_crc),
        .din   (ser_in),
        .q     (chk_q)
    );

    trig_rx_crc8 #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (cap_pay),
        .din   (ser_in),
        .crc   (crc_calc)
    );

    // The last check bit is still on the line when the verdict is taken.
    assign crc_rx = {chk_q, ser_in};
    assign crc_ok = (crc_rx == crc_calc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            resync      <= 1'b0;
            crc_err     <= 1'b0;
            trig_full   <= 1'b0;
            ch_mask     <= '0;
            event_id    <= '0;
            cmd         <= '0;
        end else begin
            frame_valid <= last_crc && crc_ok;
            crc_err     <= last_crc && !crc_ok;
            resync      <= last_crc && crc_ok &&
                           (pay_q[CMD_LO +: CMD_W] == RESYNC_CODE);
            if (last_crc && crc_ok) begin
                trig_full <= pay_q[FLAG_LO];
                ch_mask   <= pay_q[MASK_LO +: MASK_W];
                event_id  <= pay_q[EID_LO +: EID_W];
                cmd       <= pay_q[CMD_LO +: CMD_W];
            end
        end
    end

    // R9: verdict pulses exclude each other and last one cycle.
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && crc_err));
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);

    // R7: resync only with a delivered resync command.
    a_r7_resync_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> (frame_valid && cmd == RESYNC_CODE));

    // R6: a rejected frame leaves the delivered fields untouched.
    a_r6_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> $stable({trig_full, ch_mask, event_id, cmd}));

    // R2: outside a verdict pulse the data outputs do not move.
    a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable({trig_full, ch_mask, event_id, cmd}));

endmodule

// File: tb/sim_trig_cmd_rx.sv
module sim_trig_cmd_rx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ser_in;
    logic        frame_valid, trig_full, resync, crc_err;
    logic [7:0]  ch_mask;
    logic [31:0] event_id;
    logic [1:0]  cmd;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        bit          good;
        bit          trig;
        logic [7:0]  mask;
        logic [31:0] eid;
        logic [1:0]  cmd;
        int          cyc;
    } exp_t;

    exp_t q[$];

    // Model of what the outputs should hold (last good frame).
    bit          m_trig = 0;
    logic [7:0]  m_mask = '0;
    logic [31:0] m_eid  = '0;
    logic [1:0]  m_cmd  = '0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    trig_cmd_rx u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .frame_valid (frame_valid),
        .trig_full   (trig_full),
        .ch_mask     (ch_mask),
        .event_id    (event_id),
        .cmd         (cmd),
        .resync      (resync),
        .crc_err     (crc_err)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference CRC from R5: poly 0xD5, init 0, MSB first over 43 bits.
    function automatic logic [7:0] ref_crc(input logic [42:0] p);
        logic [7:0] c = 8'h00;
        for (int i = 42; i >= 0; i--) begin
            logic top = c[7] ^ p[i];
            c = {c[6:0], 1'b0};
            if (top) c = c ^ 8'hD5;
        end
        return c;
    endfunction

    // Driver: sends one frame and pushes the expected result.
    task automatic send(bit trig, logic [7:0] m, logic [31:0] e, logic [1:0] c, bit bad);
        logic [42:0] pay;
        logic [7:0]  crc;
        logic [51:0] frm;
        exp_t        x;
        pay = {trig, m, e, c};
        crc = ref_crc(pay);
        if (bad) crc = crc ^ 8'h5A;
        frm = {1'b1, pay, crc};
        for (int i = 51; i >= 0; i--) begin
            @(negedge clk);
            ser_in = frm[i];
        end
        if (!bad) begin
            m_trig = trig; m_mask = m; m_eid = e; m_cmd = c;
        end
        x.good = !bad; x.trig = m_trig; x.mask = m_mask;
        x.eid = m_eid; x.cmd = m_cmd; x.cyc = cyc + 1;
        q.push_back(x);
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_in = 1'b0;
        end
    endtask

    // Monitor: compares each verdict pulse against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (frame_valid || crc_err || resync)) begin
            if (q.size() == 0) begin
                chk("R2", "unexpected pulse", {29'd0, frame_valid, crc_err, resync}, 32'd0);
            end else begin
                exp_t x;
                x = q.pop_front();
                chk("R3", "pulse cycle", cyc, x.cyc);
                chk("R5", "frame_valid", frame_valid, x.good);
                chk("R6", "crc_err", crc_err, !x.good);
                chk("R4", "trig_full", trig_full, x.trig);
                chk("R3", "ch_mask", ch_mask, x.mask);
                chk("R3", "event_id", event_id, x.eid);
                chk("R3", "cmd", cmd, x.cmd);
                chk("R7", "resync", resync, x.good && x.cmd == 2'd3);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values.
        chk("R1", "pulses", {frame_valid, crc_err, resync}, 3'b000);
        chk("R1", "trig_full", trig_full, 1'b0);
        chk("R1", "ch_mask", ch_mask, 8'h00);
        chk("R1", "event_id", event_id, 32'h0);
        chk("R1", "cmd", cmd, 2'd0);

        // R2: long idle stretch; any pulse is flagged by the monitor.
        quiet(100);
        chk("R2", "fields after idle", event_id, 32'h0);

        // R3/R4/R5: full trigger and fragment.
        send(1'b1, 8'hA5, 32'h1234_5678, 2'd0, 1'b0);
        quiet(5);
        send(1'b0, 8'h3C, 32'hDEAD_BEEF, 2'd1, 1'b0);
        quiet(3);
        // R7: resync command, good CRC.
        send(1'b1, 8'hFF, 32'h0000_0001, 2'd3, 1'b0);
        quiet(4);
        // R6/R7: resync command with bad CRC -> error, no resync, fields held.
        send(1'b0, 8'h00, 32'hCAFE_F00D, 2'd3, 1'b1);
        quiet(4);
        // R5: extreme fields.
        send(1'b0, 8'h00, 32'h0000_0000, 2'd0, 1'b0);
        quiet(2);
        send(1'b1, 8'hFF, 32'hFFFF_FFFF, 2'd2, 1'b0);
        // R8: back-to-back frames, no gap after the last CRC bit.
        send(1'b0, 8'h55, 32'h8000_0001, 2'd3, 1'b0);
        send(1'b1, 8'hAA, 32'h0F0F_F0F0, 2'd1, 1'b1);
        send(1'b1, 8'h81, 32'h7654_3210, 2'd2, 1'b0);
        quiet(6);
        // R6: error directly after reset-like zero fields is still held.
        send(1'b1, 8'h01, 32'h0000_00FF, 2'd0, 1'b1);
        quiet(50);
        // R2: idle after all traffic keeps the last good fields.
        chk("R2", "event_id held", event_id, 32'h7654_3210);
        chk("R5", "all frames seen", q.size(), 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule